// File: doc/BRIEF.md
# PCIe Legacy INTx Aggregator

This block sits in a PCIe root port and turns the legacy interrupt messages arriving from the link into level-style interrupt state. Each accepted message names one of the four legacy lines (A to D) and says whether that line goes active or inactive. The block tracks whether each line is currently active. It also keeps a sticky pending bit per line that mimics a level-sensitive interrupt. Each line has its own mask bit. Every line that is both pending and unmasked drives a single interrupt output toward the host.

Software reaches the block through a plain 32-bit register port with a write strobe and a combinational read path. One register holds the per-line unmask bits. The other shows the pending bits, which software clears by writing ones. A clear is refused while the line is still active, so a pending bit can only be retired after the device has withdrawn its request. Messages enter on a valid/ready handshake. `msg_ready` is low while reset is applied and high from the first clock edge after reset is released. The block never applies back-pressure after that, so a message is taken on every edge where `msg_valid` and `msg_ready` are both high.

Top module: `intx_aggregator`

## Requirements
- R1: After reset, every unmask bit, pending bit and line-active state is zero, `irq_o` is low and both registers read zero.
- R2: An accepted message with `msg_deassert`=0 on line n (0=A … 3=D) sets pending bit 24+n of the status register (offset 0x184) at that clock edge.
- R3: Writing a 1 to a pending bit of the status register clears it when its line is inactive; writing 0 to a pending bit leaves it unchanged.
- R4: While a line is active (after an activate message and before the matching `msg_deassert`=1 message), a clear write to its pending bit has no effect. The deactivate message alone does not clear the pending bit.
- R5: An activate message and a clear write for the same line in the same cycle leave the pending bit set. A repeated activate message on an already active line changes nothing.
- R6: Writing the enable register (offset 0x180) loads bits 24..27 as the unmask bits for lines A..D, and reading it returns them at the same positions.
- R7: `irq_o` is high exactly when at least one line has both its pending bit and its unmask bit set.
- R8: A pending bit is recorded while its line is masked. Unmasking that line raises `irq_o` directly after the enable write.
- R9: Register bits outside 24..27 read as zero and ignore writes. Writes to any address other than 0x180 and 0x184 are ignored, and such addresses read zero.
- R10: `msg_ready` is low during reset and high afterwards. A cycle with `msg_valid` low changes no state, whatever the other message inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Message event present |
| msg_ready | output | 1 | Block accepts a message this cycle |
| msg_line | input | 2 | Line index, 0=A to 3=D |
| msg_deassert | input | 1 | 0 = line goes active, 1 = line goes inactive |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Combined interrupt to the host |

## Verification
The main function is exercised with a sequence of operations that interleaves activate and deactivate messages, mask changes and clear writes on different lines. Pending bits are collected while lines are masked and then exposed by unmasking. The sequence separates a sticky bit from a plain level, and a refused clear (line still active) from an accepted one. Later steps check that a zero in a clear write, or a second activate, leaves state alone. They also move the interrupt from one unmasked line to another, which shows that the output follows the AND of pending and unmask per line and not just any pending bit. Directed cases cover a clear write and an activate message landing in the same cycle, stray writes to reserved bits and addresses, idle message inputs, and a reset in the middle of operation.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam int INTX_LINES = 4;
  localparam int INTX_LSB   = 24;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 12;
  localparam logic [ADDR_W-1:0] ENABLE_OFS = 12'h180;
  localparam logic [ADDR_W-1:0] STATUS_OFS = 12'h184;

  typedef enum logic {
    EVT_RAISE = 1'b0,
    EVT_DROP  = 1'b1
  } intx_evt_e;
endpackage

// File: rtl/intx_msg_decode.sv
module intx_msg_decode #(
  parameter int LINES = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [SEL_W-1:0] line_i,
  input  logic             deassert_i,
  output logic [LINES-1:0] raise_o,
  output logic [LINES-1:0] drop_o
);
  import intx_pkg::*;

  logic      ready_q;
  logic      take;
  intx_evt_e kind;

  // ready rises on the first edge after reset release and stays up
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign ready_o = ready_q;
  assign take    = valid_i & ready_q;
  assign kind    = intx_evt_e'(deassert_i);

  for (genvar g = 0; g < LINES; g++) begin : g_line_hit
    logic hit;
    assign hit        = take && (line_i == SEL_W'(g));
    assign raise_o[g] = hit && (kind == EVT_RAISE);
    assign drop_o[g]  = hit && (kind == EVT_DROP);
  end
endmodule

// File: rtl/intx_line_state.sv
module intx_line_state (
  input  logic clk,
  input  logic rst_n,
  input  logic raise_i,
  input  logic drop_i,
  input  logic clr_i,
  output logic active_o,
  output logic pend_o
);
  logic active_q;
  logic pend_q;

  // remote line level as reported by messages
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       active_q <= 1'b0;
    else if (raise_i) active_q <= 1'b1;
    else if (drop_i)  active_q <= 1'b0;
  end

  // sticky pending bit: clear only honoured once the line is inactive
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pend_q <= 1'b0;
    else if (raise_i)              pend_q <= 1'b1;
    else if (clr_i && !active_q)   pend_q <= 1'b0;
  end

  assign active_o = active_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/intx_reg_port.sv
module intx_reg_port #(
  parameter int LINES  = 4,
  parameter int LSB    = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] EN_OFS = 12'h180,
  parameter logic [ADDR_W-1:0] ST_OFS = 12'h184
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LINES-1:0]  pend_i,
  output logic [LINES-1:0]  en_o,
  output logic [LINES-1:0]  clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HI = LSB + LINES;

  logic [LINES-1:0] en_q;
  logic [LINES-1:0] field;
  logic             hit_en;
  logic             hit_st;
  logic             unused_wbits;

  assign field  = wdata_i[LSB +: LINES];
  assign hit_en = (addr_i == EN_OFS);
  assign hit_st = (addr_i == ST_OFS);

  generate
    if (LSB > 0 && HI < DATA_W) begin : g_spare_both
      assign unused_wbits = ^{wdata_i[LSB-1:0], wdata_i[DATA_W-1:HI]};
    end else if (LSB > 0) begin : g_spare_low
      assign unused_wbits = ^wdata_i[LSB-1:0];
    end else if (HI < DATA_W) begin : g_spare_high
      assign unused_wbits = ^wdata_i[DATA_W-1:HI];
    end else begin : g_spare_none
      assign unused_wbits = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                en_q <= '0;
    else if (wen_i && hit_en)  en_q <= field;
  end

  assign en_o  = en_q;
  assign clr_o = (wen_i && hit_st) ? field : '0;

  always_comb begin
    rdata_o = '0;
    if (hit_en)      rdata_o[LSB +: LINES] = en_q;
    else if (hit_st) rdata_o[LSB +: LINES] = pend_i;
  end
endmodule

// File: rtl/intx_aggregator.sv
module intx_aggregator #(
  parameter int LINES  = intx_pkg::INTX_LINES,
  parameter int LSB    = intx_pkg::INTX_LSB,
  parameter int DATA_W = intx_pkg::REG_W,
  parameter int ADDR_W = intx_pkg::ADDR_W,
  parameter logic [ADDR_W-1:0] EN_OFS = intx_pkg::ENABLE_OFS,
  parameter logic [ADDR_W-1:0] ST_OFS = intx_pkg::STATUS_OFS,
  localparam int SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [SEL_W-1:0]  msg_line,
  input  logic              msg_deassert,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic [LINES-1:0] line_raise;
  logic [LINES-1:0] line_drop;
  logic [LINES-1:0] line_clr;
  logic [LINES-1:0] line_active;
  logic [LINES-1:0] line_pend;
  logic [LINES-1:0] line_en;

  intx_msg_decode #(
    .LINES (LINES),
    .SEL_W (SEL_W)
  ) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (msg_valid),
    .ready_o    (msg_ready),
    .line_i     (msg_line),
    .deassert_i (msg_deassert),
    .raise_o    (line_raise),
    .drop_o     (line_drop)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    intx_line_state u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .raise_i  (line_raise[g]),
      .drop_i   (line_drop[g]),
      .clr_i    (line_clr[g]),
      .active_o (line_active[g]),
      .pend_o   (line_pend[g])
    );
  end

  intx_reg_port #(
    .LINES  (LINES),
    .LSB    (LSB),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .EN_OFS (EN_OFS),
    .ST_OFS (ST_OFS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wen_i   (reg_wen),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .pend_i  (line_pend),
    .en_o    (line_en),
    .clr_o   (line_clr),
    .rdata_o (reg_rdata)
  );

  // single parent interrupt: any unmasked pending line
  assign irq_o = |(line_pend & line_en);
endmodule

// File: rtl/intx_aggregator_chk.sv
module intx_aggregator_chk #(
  parameter int LINES  = 4,
  parameter int LSB    = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int SEL_W  = 2,
  parameter logic [ADDR_W-1:0] EN_OFS = 12'h180,
  parameter logic [ADDR_W-1:0] ST_OFS = 12'h184
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [SEL_W-1:0]  msg_line,
  input logic              msg_deassert,
  input logic              reg_wen,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [LINES-1:0]  level,
  input logic [LINES-1:0]  pend,
  input logic [LINES-1:0]  en
);
  localparam logic [DATA_W-1:0] FIELD_MASK =
    {{(DATA_W-LINES){1'b0}}, {LINES{1'b1}}} << LSB;

  assert_ready_after_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> msg_ready);

  assert_enable_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == EN_OFS) |=> en == $past(reg_wdata[LSB +: LINES]));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~FIELD_MASK) == '0);

  for (genvar g = 0; g < LINES; g++) begin : g_chk
    assert_raise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready && !msg_deassert && msg_line == SEL_W'(g)) |=> pend[g]);

    assert_active_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      level[g] |-> pend[g]);

    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[g] && !(reg_wen && reg_addr == ST_OFS && reg_wdata[LSB+g])) |=> pend[g]);
  end
endmodule

bind intx_aggregator intx_aggregator_chk #(
  .LINES  (LINES),
  .LSB    (LSB),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .SEL_W  (SEL_W),
  .EN_OFS (EN_OFS),
  .ST_OFS (ST_OFS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .msg_valid    (msg_valid),
  .msg_ready    (msg_ready),
  .msg_line     (msg_line),
  .msg_deassert (msg_deassert),
  .reg_wen      (reg_wen),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .level        (line_active),
  .pend         (line_pend),
  .en           (line_en)
);

// File: tb/sim_intx_aggregator.sv
module sim_intx_aggregator;
  localparam logic [11:0] A_EN = 12'h180;
  localparam logic [11:0] A_ST = 12'h184;
  localparam int NV = 18;

  // vector: op(2) arg(4) exp_status(4) exp_enable(4) exp_irq(1)
  // op 0 = activate line arg, 1 = deactivate line arg, 2 = write enable nibble, 3 = clear-write nibble
  localparam logic [14:0] VEC [NV] = '{
    {2'd0, 4'd0, 4'b0001, 4'b0000, 1'b0},  // R2 raise A while masked
    {2'd2, 4'b0001, 4'b0001, 4'b0001, 1'b1},  // R6 R7 unmask A
    {2'd3, 4'b0001, 4'b0001, 4'b0001, 1'b1},  // R4 clear refused, A active
    {2'd1, 4'd0, 4'b0001, 4'b0001, 1'b1},  // R4 drop keeps pending
    {2'd3, 4'b0001, 4'b0000, 4'b0001, 1'b0},  // R3 clear accepted
    {2'd0, 4'd3, 4'b1000, 4'b0001, 1'b0},  // R8 D pending while masked
    {2'd2, 4'b1001, 4'b1000, 4'b1001, 1'b1},  // R8 unmask raises irq
    {2'd3, 4'b0000, 4'b1000, 4'b1001, 1'b1},  // R3 zero write no effect
    {2'd0, 4'd3, 4'b1000, 4'b1001, 1'b1},  // R5 repeated raise
    {2'd0, 4'd1, 4'b1010, 4'b1001, 1'b1},  // R2 raise B
    {2'd2, 4'b0010, 4'b1010, 4'b0010, 1'b1},  // R7 only B unmasked
    {2'd1, 4'd3, 4'b1010, 4'b0010, 1'b1},
    {2'd3, 4'b1000, 4'b0010, 4'b0010, 1'b1},  // R3 clear D
    {2'd1, 4'd1, 4'b0010, 4'b0010, 1'b1},
    {2'd3, 4'b1111, 4'b0000, 4'b0010, 1'b0},  // R3 clear all
    {2'd0, 4'd2, 4'b0100, 4'b0010, 1'b0},  // R7 pending C masked
    {2'd2, 4'b0000, 4'b0100, 4'b0000, 1'b0},
    {2'd2, 4'b0100, 4'b0100, 4'b0100, 1'b1}   // R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic        msg_ready;
  logic [1:0]  msg_line = '0;
  logic        msg_deassert = 1'b0;
  logic        reg_wen = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  intx_aggregator u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .msg_valid    (msg_valid),
    .msg_ready    (msg_ready),
    .msg_line     (msg_line),
    .msg_deassert (msg_deassert),
    .reg_wen      (reg_wen),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .irq_o        (irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_msg(input logic [1:0] line, input logic drop);
    @(negedge clk);
    msg_valid = 1'b1; msg_line = line; msg_deassert = drop;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic write_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0; reg_wdata = '0;
  endtask

  task automatic read_reg(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    // R1 / R10: reset state
    repeat (3) @(negedge clk);
    check("R10 ready low in reset", {31'd0, msg_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready after reset", {31'd0, msg_ready}, 32'd1);
    read_reg(A_EN, rd); check("R1 enable reset", rd, 32'd0);
    read_reg(A_ST, rd); check("R1 status reset", rd, 32'd0);
    check("R1 irq reset", {31'd0, irq_o}, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [3:0] arg;
      op  = VEC[i][14:13];
      arg = VEC[i][12:9];
      case (op)
        2'd0: send_msg(arg[1:0], 1'b0);
        2'd1: send_msg(arg[1:0], 1'b1);
        2'd2: write_reg(A_EN, {4'd0, arg, 24'd0});
        default: write_reg(A_ST, {4'd0, arg, 24'd0});
      endcase
      read_reg(A_ST, rd); check($sformatf("R2/R3/R4 status step %0d", i), rd, {4'd0, VEC[i][8:5], 24'd0});
      read_reg(A_EN, rd); check($sformatf("R6 enable step %0d", i), rd, {4'd0, VEC[i][4:1], 24'd0});
      check($sformatf("R7/R8 irq step %0d", i), {31'd0, irq_o}, {31'd0, VEC[i][0]});
    end

    // R5: activate and clear on the same line in one cycle (C inactive first)
    send_msg(2'd2, 1'b1);
    write_reg(A_ST, 32'h0400_0000);
    read_reg(A_ST, rd); check("R3 clear C after drop", rd, 32'd0);
    @(negedge clk);
    msg_valid = 1'b1; msg_line = 2'd2; msg_deassert = 1'b0;
    reg_wen = 1'b1; reg_addr = A_ST; reg_wdata = 32'h0400_0000;
    @(negedge clk);
    msg_valid = 1'b0; reg_wen = 1'b0; reg_wdata = '0;
    read_reg(A_ST, rd); check("R5 raise wins over clear", rd, 32'h0400_0000);
    check("R7 irq with C unmasked", {31'd0, irq_o}, 32'd1);

    // R10: idle message inputs change nothing
    send_msg(2'd2, 1'b1);
    @(negedge clk);
    msg_valid = 1'b0; msg_line = 2'd0; msg_deassert = 1'b0;
    @(negedge clk);
    write_reg(A_ST, 32'h0100_0000);
    read_reg(A_ST, rd); check("R10 no raise when valid low", rd, 32'h0400_0000);

    // R9: reserved bits and foreign addresses
    write_reg(A_EN, 32'hFFFF_FFFF);
    read_reg(A_EN, rd); check("R9 reserved enable bits", rd, 32'h0F00_0000);
    write_reg(12'h188, 32'h0000_0000);
    read_reg(A_EN, rd); check("R9 foreign write ignored", rd, 32'h0F00_0000);
    read_reg(12'h188, rd); check("R9 foreign read zero", rd, 32'd0);
    write_reg(A_ST, 32'hF0FF_FFFF);
    read_reg(A_ST, rd); check("R9 status reserved clear ignored", rd, 32'h0400_0000);

    // R1: reset mid-run clears everything
    send_msg(2'd1, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    read_reg(A_EN, rd); check("R1 enable after reset", rd, 32'd0);
    read_reg(A_ST, rd); check("R1 status after reset", rd, 32'd0);
    check("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    write_reg(A_EN, 32'h0F00_0000);
    check("R1 no stale pending", {31'd0, irq_o}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule